// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one logic cell of a programmable array. A 32-entry truth table drives two function outputs, F and G, from five cell inputs A to E. In merged mode the table is a single function of all five inputs. In split mode it acts as two independent functions of A to D. Each of the two flip-flops takes its data from F, from G, or from a direct data input. Both flip-flops share one clock, one clock enable and one reset. Each of the two cell outputs shows either a function value or a register value.

All settings live in one serial chain. The chain is loaded one bit per clock while the shift strobe is high. While the chain is loading, the cell holds its registers cleared and drives both outputs low. The chain is not touched by reset, so a loaded setting survives a reset pulse. The usual start-up is to shift the whole string in while reset is still asserted.

Top module: `lcb_cell`

## Requirements
- R1: In merged mode, F equals table entry {E,D,C,B,A}, where A = lut_in[0] is the least significant address bit and E = lut_in[4]. G equals F.
- R2: In split mode, F equals table entry {0,D,C,B,A} and G equals table entry {1,D,C,B,A}. Input E has no effect on either output.
- R3: The chain holds 39 bits. On each clock edge with cfg_shift high, one bit of cfg_bit enters the chain. For a string sent as stream positions 0..38, the fields are: positions 0–31 are table entries 0–31; 32–33 are the Q1 data select, lsb first; 34–35 are the Q2 data select, lsb first; 36 is the X source; 37 is the Y source; 38 is the mode (1 = merged, 0 = split). The setting changes only while cfg_shift is high.
- R4: The flip-flop data select codes are: 0 takes F, 1 takes G, and 2 or 3 takes dir_in.
- R5: With cfg_shift low, both flip-flops load their selected data on a clock edge where ce is high. They keep their value on a clock edge where ce is low.
- R6: rst_n low at a clock edge clears both flip-flops, whatever the value of ce. Reset leaves the loaded setting unchanged.
- R7: While cfg_shift is high, out_x and out_y are 0, and both flip-flops are cleared at every clock edge.
- R8: With X source 0, out_x shows F; with X source 1, it shows Q1. With Y source 0, out_y shows G; with Y source 1, it shows Q2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, shared by both flip-flops and the chain |
| rst_n | input | 1 | Active-low synchronous reset for both flip-flops |
| cfg_shift | input | 1 | Shift strobe for the setting chain |
| cfg_bit | input | 1 | Serial setting bit |
| lut_in | input | 5 | Function inputs; bit 0 is A and bit 4 is E |
| dir_in | input | 1 | Direct data input for the flip-flops |
| ce | input | 1 | Common clock enable |
| out_x | output | 1 | Cell output X, either F or Q1 |
| out_y | output | 1 | Cell output Y, either G or Q2 |

## Verification
The assertions take for granted that the setting chain holds a complete, defined string whenever reset is released. They also assume that cfg_shift stays low between loads, so that the table and selects seen by the checker are the ones in use. The stimulus always shifts a full 39-bit string, either under reset or as one uninterrupted burst. It lowers cfg_shift only after the last bit. The function inputs, the direct input and ce are random in each cycle, and only the reset pulse and the E-toggle sequence are steered by hand.

// File: rtl/lcb_pkg.sv
// Shared definitions for the lookup-table logic cell.
// Assumes a 2-bit flip-flop data select field in the setting chain.
package lcb_pkg;
    localparam int DSEL_W = 2;

    // Source codes for the flip-flop data select field.
    typedef enum logic [DSEL_W-1:0] {
        DSEL_F   = 2'd0,
        DSEL_G   = 2'd1,
        DSEL_DIR = 2'd2,
        DSEL_ALT = 2'd3
    } dsel_e;
endpackage

// File: rtl/lcb_cfg_chain.sv
// Serial setting chain and field decode.
// Stream position k sits at sr[CW-1-k] once all CW bits have been shifted.
// Assumes the caller shifts exactly CW bits per load; there is no reset.
module lcb_cfg_chain
    import lcb_pkg::*;
#(
    parameter int N_IN = 5,
    parameter int N_FF = 2
) (
    input  logic                             clk,
    input  logic                             shift_en,
    input  logic                             shift_din,
    output logic [(1<<N_IN)-1:0]             truth,
    output logic [N_FF-1:0][DSEL_W-1:0]      ff_sel,
    output logic                             x_reg,
    output logic                             y_reg,
    output logic                             merged
);
    localparam int TBL = 1 << N_IN;
    localparam int CW  = TBL + N_FF*DSEL_W + 3;
    localparam int OFS_SEL = TBL;
    localparam int OFS_OUT = TBL + N_FF*DSEL_W;

    logic [CW-1:0] sr;

    // Move the chain one place and take the new bit at the low end.
    always_ff @(posedge clk) begin
        if (shift_en) sr <= {sr[CW-2:0], shift_din};
    end

    for (genvar i = 0; i < TBL; i++) begin : g_tbl
        assign truth[i] = sr[CW-1-i];
    end

    for (genvar j = 0; j < N_FF; j++) begin : g_ff
        for (genvar b = 0; b < DSEL_W; b++) begin : g_bit
            assign ff_sel[j][b] = sr[CW-1-(OFS_SEL + j*DSEL_W + b)];
        end
    end

    assign x_reg  = sr[CW-1-OFS_OUT];
    assign y_reg  = sr[CW-1-(OFS_OUT+1)];
    assign merged = sr[CW-1-(OFS_OUT+2)];
endmodule

// File: rtl/lcb_lut_gen.sv
// Function generator: a single table, read as one N_IN-input function or as
// two (N_IN-1)-input halves. Address bit 0 is the first input.
// Assumes a table of 2**N_IN entries.
module lcb_lut_gen #(
    parameter int N_IN = 5
) (
    input  logic [(1<<N_IN)-1:0] truth,
    input  logic [N_IN-1:0]      sel,
    input  logic                 merged,
    output logic                 f,
    output logic                 g
);
    logic [N_IN-2:0] lo;

    // Look up both outputs; the top address bit comes from the last input only when merged.
    always_comb begin
        lo = sel[N_IN-2:0];
        if (merged) begin
            f = truth[sel];
            g = truth[sel];
        end else begin
            f = truth[{1'b0, lo}];
            g = truth[{1'b1, lo}];
        end
    end
endmodule

// File: rtl/lcb_cell_regs.sv
// Cell flip-flops. Each one takes F, G or the direct input, as its select
// field says. A synchronous clear (reset or loading) takes priority over ce.
// Assumes sel is stable outside loading.
module lcb_cell_regs
    import lcb_pkg::*;
#(
    parameter int N_FF = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        ce,
    input  logic                        f,
    input  logic                        g,
    input  logic                        dir,
    input  logic [N_FF-1:0][DSEL_W-1:0] sel,
    output logic [N_FF-1:0]             q
);
    for (genvar i = 0; i < N_FF; i++) begin : g_ff
        logic d;
        logic q_bit;

        // Pick this flip-flop's data source.
        always_comb begin
            case (dsel_e'(sel[i]))
                DSEL_F:  d = f;
                DSEL_G:  d = g;
                default: d = dir;
            endcase
        end

        // Clear on reset or loading, otherwise load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) q_bit <= 1'b0;
            else if (ce)       q_bit <= d;
        end

        assign q[i] = q_bit;
    end
endmodule

// File: rtl/lcb_cell.sv
// Top of the logic cell: setting chain, function generator, two flip-flops
// and the two output selectors. Outputs are held low while loading.
// Assumes a full string is shifted in before reset is released.
module lcb_cell
    import lcb_pkg::*;
#(
    parameter int N_IN = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_shift,
    input  logic            cfg_bit,
    input  logic [N_IN-1:0] lut_in,
    input  logic            dir_in,
    input  logic            ce,
    output logic            out_x,
    output logic            out_y
);
    localparam int TBL  = 1 << N_IN;
    localparam int N_FF = 2;

    logic [TBL-1:0]               truth;
    logic [N_FF-1:0][DSEL_W-1:0]  sel_q;
    logic                         x_reg;
    logic                         y_reg;
    logic                         merged;
    logic                         f_val;
    logic                         g_val;
    logic [N_FF-1:0]              q_r;

    lcb_cfg_chain #(.N_IN(N_IN), .N_FF(N_FF)) u_chain (
        .clk      (clk),
        .shift_en (cfg_shift),
        .shift_din(cfg_bit),
        .truth    (truth),
        .ff_sel   (sel_q),
        .x_reg    (x_reg),
        .y_reg    (y_reg),
        .merged   (merged)
    );

    lcb_lut_gen #(.N_IN(N_IN)) u_lut (
        .truth (truth),
        .sel   (lut_in),
        .merged(merged),
        .f     (f_val),
        .g     (g_val)
    );

    lcb_cell_regs #(.N_FF(N_FF)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cfg_shift),
        .ce   (ce),
        .f    (f_val),
        .g    (g_val),
        .dir  (dir_in),
        .sel  (sel_q),
        .q    (q_r)
    );

    // Output selectors, forced low while the chain is loading.
    always_comb begin
        out_x = cfg_shift ? 1'b0 : (x_reg ? q_r[0] : f_val);
        out_y = cfg_shift ? 1'b0 : (y_reg ? q_r[1] : g_val);
    end
endmodule

// File: rtl/lcb_cell_chk.sv
// Property checker for lcb_cell, bound to every instance.
// Assumes the chain holds a complete string whenever rst_n is high.
module lcb_cell_chk
    import lcb_pkg::*;
#(
    parameter int N_IN = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_shift,
    input logic                  ce,
    input logic                  out_x,
    input logic                  out_y,
    input logic                  f,
    input logic                  g,
    input logic                  merged,
    input logic [(1<<N_IN)-1:0]  truth,
    input logic [DSEL_W-1:0]     sel0,
    input logic [1:0]            q
);
    p_quiet_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |-> (!out_x && !out_y));

    p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (q == 2'b00));

    p_merged_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_shift && merged) |-> (f == g));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !cfg_shift) |=> (q == $past(q)));

    p_take_f_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !cfg_shift && sel0 == DSEL_F) |=> (q[0] == $past(f)));

    p_setting_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(truth));
endmodule

bind lcb_cell lcb_cell_chk #(.N_IN(N_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_shift(cfg_shift),
    .ce       (ce),
    .out_x    (out_x),
    .out_y    (out_y),
    .f        (f_val),
    .g        (g_val),
    .merged   (merged),
    .truth    (truth),
    .sel0     (sel_q[0]),
    .q        (q_r)
);

// File: tb/tb_lcb_cell.sv
// Bench for lcb_cell: a behavioural model, with the setting kept as a queue
// of shifted bits, is compared with both outputs on every clock.
module tb_lcb_cell;
    localparam time CLK_P = 20ns;
    localparam int  CW    = 39;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [4:0] lut_in = '0;
    logic       dir_in = 1'b0;
    logic       ce = 1'b0;
    logic       out_x;
    logic       out_y;

    int checks = 0;
    int failures = 0;

    bit sq[$];
    bit m_q1 = 1'b0;
    bit m_q2 = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lcb_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
        .lut_in(lut_in), .dir_in(dir_in), .ce(ce), .out_x(out_x), .out_y(out_y)
    );

    function automatic bit m_merged();
        return sq[38];
    endfunction

    function automatic int m_sel(input int ff);
        return int'(sq[32+2*ff]) + 2*int'(sq[33+2*ff]);
    endfunction

    function automatic bit m_f(input logic [4:0] a);
        int idx;
        idx = m_merged() ? int'(a) : int'(a[3:0]);
        return sq[idx];
    endfunction

    function automatic bit m_g(input logic [4:0] a);
        int idx;
        idx = m_merged() ? int'(a) : 16 + int'(a[3:0]);
        return sq[idx];
    endfunction

    function automatic bit m_d(input int ff, input logic [4:0] a, input bit di);
        int s;
        s = m_sel(ff);
        if (s == 0) return m_f(a);
        if (s == 1) return m_g(a);
        return di;
    endfunction

    task automatic chk(input string req, input string what, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance the model.
    task automatic cyc(input string req, input bit rn, input bit cs, input bit cb,
                       input logic [4:0] li, input bit di, input bit cen);
        bit ex, ey;
        @(negedge clk);
        rst_n = rn; cfg_shift = cs; cfg_bit = cb; lut_in = li; dir_in = di; ce = cen;
        #1;
        if (cs) begin
            ex = 1'b0; ey = 1'b0;
        end else begin
            ex = sq[36] ? m_q1 : m_f(li);
            ey = sq[37] ? m_q2 : m_g(li);
        end
        chk(req, "out_x", out_x, ex);
        chk(req, "out_y", out_y, ey);
        if (!rn || cs) begin
            m_q1 = 1'b0; m_q2 = 1'b0;
        end else if (cen) begin
            m_q1 = m_d(0, li, di);
            m_q2 = m_d(1, li, di);
        end
        if (cs) begin
            sq.push_back(cb);
            if (sq.size() > CW) void'(sq.pop_front());
        end
    endtask

    // Shift a full setting string, stream position 0 first.
    task automatic load(input string req, input bit rn, input logic [31:0] tbl,
                        input logic [1:0] s1, input logic [1:0] s2,
                        input bit xr, input bit yr, input bit mg);
        bit stream[CW];
        for (int k = 0; k < 32; k++) stream[k] = tbl[k];
        stream[32] = s1[0]; stream[33] = s1[1];
        stream[34] = s2[0]; stream[35] = s2[1];
        stream[36] = xr; stream[37] = yr; stream[38] = mg;
        for (int k = 0; k < CW; k++)
            cyc(req, rn, 1'b1, stream[k], 5'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic run_rand(input string req, input int n);
        for (int i = 0; i < n; i++)
            cyc(req, 1'b1, 1'b0, 1'b0, 5'($urandom), 1'($urandom), 1'($urandom));
    endtask

    initial begin
        #(CLK_P * 50000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Reset state and loading under reset: outputs low (R7), merged setting.
        load("R7 R3", 1'b0, 32'hE8C1_7A35, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1);
        // Merged function on X, Q2 from the direct input on Y.
        run_rand("R1 R4 R5 R8", 40);
        // Reset with ce high clears the registers and keeps the setting.
        cyc("R6", 1'b0, 1'b0, 1'b0, 5'h13, 1'b1, 1'b1);
        cyc("R6", 1'b1, 1'b0, 1'b0, 5'h07, 1'b1, 1'b0);
        cyc("R6", 1'b1, 1'b0, 1'b0, 5'h1C, 1'b0, 1'b0);
        run_rand("R6 R1", 6);
        // Split setting loaded live; Q1 from direct on X, G on Y.
        load("R3 R7", 1'b1, 32'h5A0F_96C3, 2'd3, 2'd1, 1'b1, 1'b0, 1'b0);
        run_rand("R2 R3 R4 R5 R8", 40);
        // E has no effect in split mode.
        for (int i = 0; i < 8; i++)
            cyc("R2", 1'b1, 1'b0, 1'b0, {i[0], 4'(i * 3)}, 1'b0, 1'b1);
        // Split, both outputs registered: Q1 from G, Q2 from F.
        load("R7", 1'b1, 32'h3C3C_A5A5, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
        run_rand("R4 R5 R8", 30);
        // Merged, both outputs combinational.
        load("R3 R7", 1'b1, 32'h9D26_41BF, 2'd2, 2'd3, 1'b0, 1'b0, 1'b1);
        run_rand("R1 R8", 20);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule